// File: doc/BRIEF.md
# Accumulator Datapath Core

This block is the execute stage of a very small processor. It holds an accumulator `acc` and one scratch register `rreg`, reads a data input bus, and drives a registered output bus together with a valid strobe. Each clock edge carries out exactly one operation, chosen by a 4-bit operation code. The operations load from the input bus, copy between registers, write a register to the output, add, OR, AND and complement.

An external sequencer presents one operation code on every cycle. Fetch, program counter, memory and flags are not part of this block. The data width is set by the parameter `W`, which defaults to 8. Both registers are brought out as ports so that a tester can observe them.

Top module: `acc_core`

## Requirements
- R1: On a synchronous reset, `acc`, `rreg` and `dout` become 0 and `dout_vld` becomes 0.
- R2: Code 1 and code 6 each load `acc` from `din` at the next clock edge.
- R3: Code 2 copies `acc` into `rreg`. Code 5 loads `rreg` from `din`.
- R4: Code 3 registers `rreg` onto `dout`. Code 4 registers `acc` onto `dout`. In both cases `dout_vld` is 1 for that one following cycle.
- R5: Code 7 sets `acc` to `acc + rreg` modulo 2^W, and the carry is discarded.
- R6: Code 8 sets `acc` to `acc | rreg`. Code 9 sets `acc` to `acc & rreg`.
- R7: Code 10 sets `acc` to `~acc`.
- R8: `rreg` keeps its value under codes 1, 3, 4 and 6 to 10. `acc` keeps its value under codes 2 to 5.
- R9: Codes 0 and 11 to 15 change no register. After any code other than 3 or 4, `dout` holds its last value and `dout_vld` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op | input | 4 | Operation code, 1 to 10 valid |
| din | input | W | Input data bus |
| dout | output | W | Registered output bus |
| dout_vld | output | 1 | One-cycle strobe for an output write |
| acc | output | W | Accumulator value |
| rreg | output | W | Scratch register value |

## Verification
The arithmetic and logic operations are driven with operand pairs chosen so that their results differ from one another. With such pairs, a swapped decode of add, OR and AND gives a visibly wrong value. Addition is also driven with operands whose sum overflows, which confirms that the result wraps. The output writes use distinct values in `acc` and `rreg`, so that the bench can tell which register reached `dout`. After each operation the bench reads both registers back, which exposes any write to the wrong register. The undefined codes are applied with `din` set to a new value, so a spurious load would change a register and be seen.

// File: rtl/acc_core.sv
module acc_core #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [3:0]   op,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         dout_vld,
  output logic [W-1:0] acc,
  output logic [W-1:0] rreg
);

  logic [W-1:0] acc_nx, rreg_nx;
  logic         wr_out;

  assign wr_out = (op == 4'd3) || (op == 4'd4);

  always_comb begin
    acc_nx  = acc;
    rreg_nx = rreg;
    case (op)
      4'd1, 4'd6: acc_nx  = din;
      4'd2:       rreg_nx = acc;
      4'd5:       rreg_nx = din;
      4'd7:       acc_nx  = acc + rreg;
      4'd8:       acc_nx  = acc | rreg;
      4'd9:       acc_nx  = acc & rreg;
      4'd10:      acc_nx  = ~acc;
      default:    ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc      <= '0;
      rreg     <= '0;
      dout     <= '0;
      dout_vld <= 1'b0;
    end else begin
      acc      <= acc_nx;
      rreg     <= rreg_nx;
      dout_vld <= wr_out;
      if (wr_out) dout <= (op == 4'd3) ? rreg : acc;
    end
  end

  p_reset_r1: assert property (@(posedge clk) rst |=> (acc == '0 && rreg == '0 && dout == '0 && !dout_vld));
  p_load_acc_r2: assert property (@(posedge clk) disable iff (rst) (op == 4'd1 || op == 4'd6) |=> acc == $past(din));
  p_load_r_r3: assert property (@(posedge clk) disable iff (rst) (op == 4'd5) |=> rreg == $past(din));
  p_out_r_r4: assert property (@(posedge clk) disable iff (rst) (op == 4'd3) |=> (dout_vld && dout == $past(rreg)));
  p_add_r5: assert property (@(posedge clk) disable iff (rst) (op == 4'd7) |=> acc == W'($past(acc) + $past(rreg)));
  p_cmp_r7: assert property (@(posedge clk) disable iff (rst) (op == 4'd10) |=> acc == ~$past(acc));
  p_keep_r_r8: assert property (@(posedge clk) disable iff (rst) (op != 4'd2 && op != 4'd5) |=> $stable(rreg));
  p_hold_out_r9: assert property (@(posedge clk) disable iff (rst) !(op == 4'd3 || op == 4'd4) |=> (!dout_vld && $stable(dout)));

endmodule

// File: tb/acc_core_tb_top.sv
module acc_core_tb_top;
  localparam int W = 8;
  logic clk = 0, rst = 1;
  logic [3:0] op = 0;
  logic [W-1:0] din = 0;
  logic [W-1:0] dout, acc, rreg;
  logic dout_vld;
  int errs = 0, checks = 0;

  always #2.5 clk = ~clk;

  acc_core #(.W(W)) dut_i (.clk, .rst, .op, .din, .dout, .dout_vld, .acc, .rreg);

  task automatic chk(string req, logic [W-1:0] got, logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic step(logic [3:0] o, logic [W-1:0] d);
    op = o; din = d;
    @(posedge clk); #1;
    op = 0;
  endtask

  task automatic t_reset;
    rst = 1; @(posedge clk); #1; rst = 0;
    chk("R1 acc", acc, 0); chk("R1 rreg", rreg, 0);
    chk("R1 dout", dout, 0); chk("R1 vld", W'(dout_vld), 0);
  endtask

  task automatic t_loads;
    step(1, 8'h3C); chk("R2 i1", acc, 8'h3C); chk("R8 r keep", rreg, 0);
    step(6, 8'hA5); chk("R2 i6", acc, 8'hA5);
    step(2, 8'hFF); chk("R3 i2", rreg, 8'hA5); chk("R8 a keep", acc, 8'hA5);
    step(5, 8'h5A); chk("R3 i5", rreg, 8'h5A); chk("R8 a keep5", acc, 8'hA5);
  endtask

  task automatic t_out;
    step(3, 0); chk("R4 i3", dout, 8'h5A); chk("R4 vld3", W'(dout_vld), 1);
    chk("R8 a keep3", acc, 8'hA5);
    step(0, 8'h11); chk("R9 vld drop", W'(dout_vld), 0); chk("R9 hold", dout, 8'h5A);
    step(4, 0); chk("R4 i4", dout, 8'hA5); chk("R4 vld4", W'(dout_vld), 1);
  endtask

  task automatic t_alu;
    step(1, 8'h0F); step(5, 8'h33);
    step(8, 0); chk("R6 or", acc, 8'h3F); chk("R8 r keep8", rreg, 8'h33);
    step(9, 0); chk("R6 and", acc, 8'h33);
    step(7, 0); chk("R5 add", acc, 8'h66);
    step(10, 0); chk("R7 not", acc, 8'h99);
    step(1, 8'hF0); step(5, 8'h25);
    step(7, 0); chk("R5 wrap", acc, 8'h15); chk("R9 no out", W'(dout_vld), 0);
  endtask

  task automatic t_nop;
    for (int c = 11; c < 16; c++) begin
      step(4'(c), 8'hEE); chk("R9 nop acc", acc, 8'h15); chk("R9 nop r", rreg, 8'h25);
    end
    step(0, 8'hEE); chk("R9 nop0", acc, 8'h15); chk("R9 out kept", dout, 8'hA5);
  endtask

  initial begin
    #200000;
    errs++; checks++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    @(posedge clk); #1;
    t_reset; t_loads; t_out; t_alu; t_nop;
    step(1, 8'h77); t_reset;
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule